// File: doc/BRIEF.md
# Low-Power Entry Sequencer

This block is the control core of a power manager. It watches the processor's wait-for-interrupt indication together with a software low-power hint and decides whether the chip may go to sleep. Before it gates the clocks, it spends one cycle checking the conditions that would make sleep unsafe or pointless: an interrupt that has just arrived, or a memory, lifecycle or fuse-controller transaction still in flight. If none applies, it turns the clocks off, waits in a sleep state, and brings the clocks back when an enabled wake source fires.

Reset requests run through the same machine. An enabled request resets the chip whether it is awake or asleep. A loss of main power-good during any transition forces the reset state. A deep-sleep select, captured when entry starts, marks the sleep as deep. The outcomes that leave no trace on the clock pins are kept in cause registers and sticky flags. These are the wake cause, the reset cause, a fall-through flag and an abort flag.

Top module: `pwrseq_top`

## Requirements
- R1: After reset the block is awake: clkEn=1, sleeping=0, sleepDeep=0, rstReq=0, and wakeCause, rstCause, fallThru and abortSeen are all 0.
- R2: While lpHint is 0, an asserted wfi never gates the clock.
- R3: While dbgActive is 1, an asserted wfi with lpHint=1 never gates the clock.
- R4: If irqPending is 1 in the cycle after entry starts, the block returns to awake without gating the clock and sets fallThru, which stays 1 until reset.
- R5: If any of nvmBusy, lcBusy or otpBusy is 1 in the check cycle and no interrupt is pending, entry aborts to awake without gating the clock and sets abortSeen, which stays 1 until reset.
- R6: A clean entry takes three edges. The first enters the check state with the clock still on. The second drops clkEn. The third raises sleeping. A wake source whose enable bit is 1 then restores clkEn=1 and sleeping=0 on the next edge. At that edge wakeCause loads wakeSrc AND wakeEn, and it holds that value until the next wake.
- R7: In sleep, a wake source whose enable bit is 0 leaves the block asleep.
- R8: A reset source whose enable bit is 0 has no effect, awake or asleep. An enabled source raises rstReq on the next edge and loads rstCause[NR-1:0] with rstSrc AND rstEn, with rstCause[NR]=0.
- R9: sleepDeep is 1 during sleep exactly when deepSel was 1 on the edge where entry began. Wake and reset both work from a normal sleep and from a deep sleep.
- R10: A reset request that arrives in the check cycle wins over a pending interrupt or busy flag, and rstReq rises on the next edge.
- R11: In any state other than awake, mainPok=0 forces the reset state on the next edge and sets rstCause to only bit NR. The reset state persists while mainPok stays 0 and returns to awake one edge after mainPok returns. When the block is awake and no reset is requested, mainPok is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wfi | input | 1 | Core is idle waiting for an interrupt |
| lpHint | input | 1 | Software permits low-power entry |
| deepSel | input | 1 | Requested sleep is deep |
| dbgActive | input | 1 | Debugger attached; blocks entry |
| nvmBusy | input | 1 | Nonvolatile-memory controller busy |
| lcBusy | input | 1 | Lifecycle controller busy |
| otpBusy | input | 1 | Fuse controller busy |
| irqPending | input | 1 | An interrupt is pending at the core |
| wakeSrc | input | NW | Wake source levels |
| wakeEn | input | NW | Wake source enables |
| rstSrc | input | NR | Reset request levels |
| rstEn | input | NR | Reset request enables |
| mainPok | input | 1 | Main supply power-good |
| clkEn | output | 1 | Clock enable to the clock manager |
| sleeping | output | 1 | Chip is in sleep |
| sleepDeep | output | 1 | Current sleep is deep |
| rstReq | output | 1 | Reset request to the reset manager |
| wakeCause | output | NW | Masked wake vector of the last wake |
| rstCause | output | NR+1 | Masked reset vector of the last reset; top bit marks power-good loss |
| fallThru | output | 1 | Sticky: an entry fell through on an interrupt |
| abortSeen | output | 1 | Sticky: an entry aborted on a busy controller |

## Verification
On every cycle, the assertions check the single-step gating rules against the machine's state. These are: no entry without the hint or with debug active, the outcome of the check cycle for interrupts and busy flags, staying asleep when no enabled wake or reset source is active, no reset from a masked source while awake, and the forced reset on power-good loss. The bench scenarios are needed for what spans several cycles or depends on captured values. That covers the exact edge-by-edge entry and wake timing, the contents of the wake and reset cause registers, the latching of the deep select, the persistence of the sticky flags, and how long the reset state is held while power-good stays low.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_CHECK   = 3'd1,
    ST_CLK_OFF = 3'd2,
    ST_SLEEP   = 3'd3,
    ST_WAKE    = 3'd4,
    ST_RESET   = 3'd5
  } pwrState_e;

  typedef struct packed {
    logic capDeep;
    logic capWake;
    logic capRst;
    logic rstByPok;
    logic markFall;
    logic markAbort;
  } seqStrobe_t;
endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wfi,
  input  logic       lpHint,
  input  logic       dbgActive,
  input  logic       irqPending,
  input  logic       anyBusy,
  input  logic       wakeHit,
  input  logic       rstHit,
  input  logic       mainPok,
  output pwrState_e  state,
  output seqStrobe_t strobe
);
  pwrState_e nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_ACTIVE: begin
        if (rstHit) begin
          nextState     = ST_RESET;
          strobe.capRst = 1'b1;
        end else if (wfi && lpHint && !dbgActive) begin
          nextState      = ST_CHECK;
          strobe.capDeep = 1'b1;
        end
      end
      ST_CHECK: begin
        if (!mainPok || rstHit) begin
          nextState       = ST_RESET;
          strobe.capRst   = 1'b1;
          strobe.rstByPok = !mainPok;
        end else if (irqPending) begin
          nextState       = ST_ACTIVE;
          strobe.markFall = 1'b1;
        end else if (anyBusy) begin
          nextState        = ST_ACTIVE;
          strobe.markAbort = 1'b1;
        end else begin
          nextState = ST_CLK_OFF;
        end
      end
      ST_CLK_OFF, ST_SLEEP, ST_WAKE: begin
        if (!mainPok || rstHit) begin
          nextState       = ST_RESET;
          strobe.capRst   = 1'b1;
          strobe.rstByPok = !mainPok;
        end else if (state == ST_CLK_OFF) begin
          nextState = ST_SLEEP;
        end else if (state == ST_WAKE) begin
          nextState = ST_ACTIVE;
        end else if (wakeHit) begin
          nextState      = ST_WAKE;
          strobe.capWake = 1'b1;
        end
      end
      ST_RESET: begin
        if (mainPok) nextState = ST_ACTIVE;
      end
      default: nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nextState;
  end
endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int NW = 4,
  parameter int NR = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          deepSel,
  input  logic          nvmBusy,
  input  logic          lcBusy,
  input  logic          otpBusy,
  input  logic [NW-1:0] wakeSrc,
  input  logic [NW-1:0] wakeEn,
  input  logic [NR-1:0] rstSrc,
  input  logic [NR-1:0] rstEn,
  input  seqStrobe_t    strobe,
  output logic          wakeHit,
  output logic          rstHit,
  output logic          anyBusy,
  output logic          deepLatched,
  output logic [NW-1:0] wakeCause,
  output logic [NR:0]   rstCause,
  output logic          fallThru,
  output logic          abortSeen
);
  localparam int NBUSY = 3;

  logic [NW-1:0]    wakeMasked;
  logic [NR-1:0]    rstMasked;
  logic [NBUSY-1:0] busyVec;

  assign busyVec = {otpBusy, lcBusy, nvmBusy};

  for (genvar i = 0; i < NW; i++) begin : g_wakeMask
    assign wakeMasked[i] = wakeSrc[i] & wakeEn[i];
  end
  for (genvar j = 0; j < NR; j++) begin : g_rstMask
    assign rstMasked[j] = rstSrc[j] & rstEn[j];
  end

  assign wakeHit = |wakeMasked;
  assign rstHit  = |rstMasked;
  assign anyBusy = |busyVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deepLatched <= 1'b0;
      wakeCause   <= '0;
      rstCause    <= '0;
      fallThru    <= 1'b0;
      abortSeen   <= 1'b0;
    end else begin
      if (strobe.capDeep)   deepLatched <= deepSel;
      if (strobe.capWake)   wakeCause   <= wakeMasked;
      if (strobe.capRst)    rstCause    <= strobe.rstByPok ? {1'b1, {NR{1'b0}}}
                                                           : {1'b0, rstMasked};
      if (strobe.markFall)  fallThru    <= 1'b1;
      if (strobe.markAbort) abortSeen   <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int NW = 4,
  parameter int NR = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wfi,
  input  logic          lpHint,
  input  logic          deepSel,
  input  logic          dbgActive,
  input  logic          nvmBusy,
  input  logic          lcBusy,
  input  logic          otpBusy,
  input  logic          irqPending,
  input  logic [NW-1:0] wakeSrc,
  input  logic [NW-1:0] wakeEn,
  input  logic [NR-1:0] rstSrc,
  input  logic [NR-1:0] rstEn,
  input  logic          mainPok,
  output logic          clkEn,
  output logic          sleeping,
  output logic          sleepDeep,
  output logic          rstReq,
  output logic [NW-1:0] wakeCause,
  output logic [NR:0]   rstCause,
  output logic          fallThru,
  output logic          abortSeen
);
  pwrState_e  state;
  seqStrobe_t strobe;
  logic       wakeHit, rstHit, anyBusy, deepLatched;

  pwrseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wfi(wfi), .lpHint(lpHint), .dbgActive(dbgActive),
    .irqPending(irqPending), .anyBusy(anyBusy), .wakeHit(wakeHit),
    .rstHit(rstHit), .mainPok(mainPok), .state(state), .strobe(strobe)
  );

  pwrseq_dp #(.NW(NW), .NR(NR)) u_dp (
    .clk(clk), .rstN(rstN), .deepSel(deepSel), .nvmBusy(nvmBusy),
    .lcBusy(lcBusy), .otpBusy(otpBusy), .wakeSrc(wakeSrc), .wakeEn(wakeEn),
    .rstSrc(rstSrc), .rstEn(rstEn), .strobe(strobe), .wakeHit(wakeHit),
    .rstHit(rstHit), .anyBusy(anyBusy), .deepLatched(deepLatched),
    .wakeCause(wakeCause), .rstCause(rstCause), .fallThru(fallThru),
    .abortSeen(abortSeen)
  );

  assign clkEn     = !(state == ST_CLK_OFF || state == ST_SLEEP);
  assign sleeping  = (state == ST_SLEEP);
  assign sleepDeep = (state == ST_SLEEP) && deepLatched;
  assign rstReq    = (state == ST_RESET);
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk
  import pwrseq_pkg::*;
#(
  parameter int NW = 4,
  parameter int NR = 2
) (
  input logic          clk,
  input logic          rstN,
  input pwrState_e     state,
  input logic          lpHint,
  input logic          dbgActive,
  input logic          irqPending,
  input logic          nvmBusy,
  input logic          lcBusy,
  input logic          otpBusy,
  input logic [NW-1:0] wakeSrc,
  input logic [NW-1:0] wakeEn,
  input logic [NR-1:0] rstSrc,
  input logic [NR-1:0] rstEn,
  input logic          mainPok,
  input logic          rstReq,
  input logic          fallThru,
  input logic          abortSeen
);
  logic noRst, noWake, busy;
  assign noRst  = ((rstSrc & rstEn) == '0);
  assign noWake = ((wakeSrc & wakeEn) == '0);
  assign busy   = nvmBusy | lcBusy | otpBusy;

  p_no_entry_nohint_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !lpHint) |=> (state != ST_CHECK));

  p_no_entry_dbg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && dbgActive) |=> (state != ST_CHECK));

  p_fall_through_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && mainPok && noRst && irqPending)
      |=> (state == ST_ACTIVE && fallThru));

  p_busy_abort_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && mainPok && noRst && !irqPending && busy)
      |=> (state == ST_ACTIVE && abortSeen));

  p_masked_wake_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && mainPok && noRst && noWake) |=> (state == ST_SLEEP));

  p_masked_rst_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && noRst) |=> !rstReq);

  p_pok_loss_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_ACTIVE && !mainPok) |=> rstReq);
endmodule

bind pwrseq_top pwrseq_chk #(.NW(NW), .NR(NR)) u_chk (
  .clk(clk), .rstN(rstN), .state(state), .lpHint(lpHint), .dbgActive(dbgActive),
  .irqPending(irqPending), .nvmBusy(nvmBusy), .lcBusy(lcBusy), .otpBusy(otpBusy),
  .wakeSrc(wakeSrc), .wakeEn(wakeEn), .rstSrc(rstSrc), .rstEn(rstEn),
  .mainPok(mainPok), .rstReq(rstReq), .fallThru(fallThru), .abortSeen(abortSeen)
);

// File: tb/pwrseq_top_test.sv
module pwrseq_top_test;
  localparam int PERIOD = 10;
  localparam int NW = 4;
  localparam int NR = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wfi = 0, lpHint = 0, deepSel = 0, dbgActive = 0;
  logic nvmBusy = 0, lcBusy = 0, otpBusy = 0, irqPending = 0, mainPok = 1;
  logic [NW-1:0] wakeSrc = '0, wakeEn = '0;
  logic [NR-1:0] rstSrc = '0, rstEn = '0;
  logic clkEn, sleeping, sleepDeep, rstReq, fallThru, abortSeen;
  logic [NW-1:0] wakeCause;
  logic [NR:0]   rstCause;

  always #(PERIOD/2) clk = ~clk;

  pwrseq_top #(.NW(NW), .NR(NR)) uut (.*);

  typedef struct {
    string tag;
    logic clk, slp, deep, rst, fall, abrt;
    logic [NW-1:0] wake;
    logic [NR:0] rc;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0, bad = 0;
  bit finished = 0;

  logic eClk = 1, eSlp = 0, eDeep = 0, eRst = 0, eFall = 0, eAbort = 0;
  logic [NW-1:0] eWake = '0;
  logic [NR:0]   eRc = '0;

  task automatic tick(input string tag);
    expItem_t it;
    it.tag = tag; it.clk = eClk; it.slp = eSlp; it.deep = eDeep; it.rst = eRst;
    it.fall = eFall; it.abrt = eAbort; it.wake = eWake; it.rc = eRc;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      total++;
      if ({clkEn, sleeping, sleepDeep, rstReq, fallThru, abortSeen, wakeCause, rstCause} !==
          {e.clk, e.slp, e.deep, e.rst, e.fall, e.abrt, e.wake, e.rc}) begin
        bad++;
        $display("FAIL %s: actual clkEn=%b sleeping=%b deep=%b rstReq=%b fall=%b abort=%b wake=%b rc=%b expected clkEn=%b sleeping=%b deep=%b rstReq=%b fall=%b abort=%b wake=%b rc=%b",
          e.tag, clkEn, sleeping, sleepDeep, rstReq, fallThru, abortSeen, wakeCause, rstCause,
          e.clk, e.slp, e.deep, e.rst, e.fall, e.abrt, e.wake, e.rc);
      end
    end
  end

  initial begin
    #(PERIOD*5000);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    tick("R1"); tick("R1");

    // R2: hint low blocks entry
    wfi = 1; lpHint = 0;
    repeat (3) tick("R2");

    // R3: debug blocks entry
    lpHint = 1; dbgActive = 1;
    repeat (3) tick("R3");

    // R4: late interrupt falls through
    dbgActive = 0; irqPending = 1;
    tick("R4");
    wfi = 0; eFall = 1;
    tick("R4"); tick("R4");
    irqPending = 0;

    // R5: busy controller aborts entry
    wfi = 1; nvmBusy = 1;
    tick("R5");
    wfi = 0; eAbort = 1;
    tick("R5");
    nvmBusy = 0;

    // R6 / R7: normal sleep, masked wake, then enabled wake
    wakeEn = 4'b0010; wakeSrc = 4'b0001; deepSel = 0; wfi = 1;
    tick("R6");
    wfi = 0; eClk = 0;
    tick("R6");
    eSlp = 1;
    tick("R6");
    repeat (3) tick("R7");
    wakeSrc = 4'b0011; eClk = 1; eSlp = 0; eWake = 4'b0010;
    tick("R6");
    wakeSrc = '0;
    tick("R6"); tick("R6");

    // R8: awake masked then enabled reset
    rstEn = 2'b01; rstSrc = 2'b10;
    repeat (2) tick("R8");
    rstSrc = 2'b01; eRst = 1; eRc = 3'b001;
    tick("R8");
    rstSrc = '0; eRst = 0;
    tick("R8");

    // R9: deep sleep, masked reset ignored, enabled reset acts
    rstEn = 2'b10; deepSel = 1; wfi = 1;
    tick("R9");
    wfi = 0; deepSel = 0; eClk = 0;
    tick("R9");
    eSlp = 1; eDeep = 1;
    tick("R9");
    rstSrc = 2'b01;
    repeat (2) tick("R8");
    rstSrc = 2'b11; eClk = 1; eSlp = 0; eDeep = 0; eRst = 1; eRc = 3'b010;
    tick("R9");
    rstSrc = '0; eRst = 0;
    tick("R9");

    // R9: deep sleep woken by enabled source
    wakeEn = 4'b1000; deepSel = 1; wfi = 1;
    tick("R9");
    wfi = 0; eClk = 0;
    tick("R9");
    eSlp = 1; eDeep = 1;
    tick("R9");
    wakeSrc = 4'b1100; eClk = 1; eSlp = 0; eDeep = 0; eWake = 4'b1000;
    tick("R9");
    wakeSrc = '0;
    tick("R9");

    // R10: reset arriving in the check cycle wins
    deepSel = 0; rstEn = 2'b01; irqPending = 1; nvmBusy = 1; wfi = 1;
    tick("R10");
    wfi = 0; rstSrc = 2'b01; eRst = 1; eRc = 3'b001;
    tick("R10");
    rstSrc = '0; irqPending = 0; nvmBusy = 0; eRst = 0;
    tick("R10");

    // R11: power-good ignored when awake, forces reset mid-transition
    mainPok = 0;
    repeat (2) tick("R11");
    mainPok = 1; wfi = 1;
    tick("R11");
    wfi = 0; eClk = 0;
    tick("R11");
    mainPok = 0; eClk = 1; eRst = 1; eRc = 3'b100;
    tick("R11"); tick("R11");
    mainPok = 1; eRst = 0;
    tick("R11");

    // R11: power-good loss while asleep
    wfi = 1;
    tick("R11");
    wfi = 0; eClk = 0;
    tick("R11");
    eSlp = 1;
    tick("R11");
    rstEn = 2'b01; rstSrc = 2'b01; mainPok = 0;
    eClk = 1; eSlp = 0; eRst = 1; eRc = 3'b100;
    tick("R11");
    mainPok = 1; rstSrc = '0; eRst = 0;
    tick("R11");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule